// File: doc/BRIEF.md
# Set-Associative Block Directory With LRU Replacement

This block keeps a small cache directory and its data words for block addresses. Each access names a block number. The block picks a set from the low bits of that number. It then compares the remaining tag bits against every way of that set at the same time and reports either a hit or a miss. On a miss the block fills a way straight away. It prefers an empty way. When the set is full it takes the way that has gone longest without use, and it reports which block that way held. There is no write policy, no dirty state and no backing-memory handshake. The word stored on a miss is whatever the requester supplies with the access.

The total block count and the number of ways are parameters. With four blocks, one way gives a direct-mapped directory, two ways give a 2-way set-associative one, and four ways give a fully associative one, all from the same code. Every access is answered by a registered response one clock later. Accesses may arrive on consecutive cycles.

Top module: `assoc_tag_dir`

## Requirements
- R1: The set index equals the block number modulo SETS = NUM_BLOCKS / WAYS, which is the low log2(SETS) bits. The tag is the block number shifted right by log2(SETS). Blocks with equal low bits compete for the same set.
- R2: An access hits when some valid way of the selected set holds its tag. The response then gives rsp_hit = 1, the matching way in rsp_way, and the data word that was stored when that block was filled.
- R3: On a miss, if the set has an invalid way, the lowest-numbered invalid way is filled. The response gives rsp_hit = 0, rsp_evict_valid = 0, that way in rsp_way, and the supplied fill word in rsp_data.
- R4: On a miss into a full set, the least-recently-used way is replaced. The response gives rsp_evict_valid = 1 and, in rsp_evict_blk, the full block number that way held. rsp_evict_valid is never 1 on a hit.
- R5: Both hits and fills make the accessed way the most recently used way of its set. All other ways keep their relative order.
- R6: The response is registered. rsp_valid is 1 exactly one cycle after a cycle with req_valid = 1, and 0 otherwise. A cycle without req_valid changes no directory state.
- R7: Reset clears every valid bit and sets the recency order of each set so that way 0 is the most recent. The first access to any set after reset misses and fills way 0.
- R8: With WAYS = 1 (direct-mapped) the reported way is always 0. The sequence 0, 8, 0, 6, 8 on 4 blocks misses every time.
- R9: On 4 blocks, the sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss with 2 ways, and miss, miss, hit, miss, hit with 4 ways. In the 2-way case the fourth access evicts block 8 and the fifth evicts block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_blk | input | ADDR_W | Block number to look up |
| req_fill_data | input | DATA_W | Word stored if the access misses |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | max(1, log2(WAYS)) | Way that hit or was filled |
| rsp_evict_valid | output | 1 | A valid block was replaced |
| rsp_evict_blk | output | ADDR_W | Block number that was replaced |
| rsp_data | output | DATA_W | Stored word on a hit, fill word on a miss |

## Verification
The same stimulus drives three copies that differ only in associativity: 1, 2 and 4 ways over 4 blocks. The set-conflict sequence 0, 8, 0, 6, 8 separates the copies by their hit patterns. It also tells LRU replacement apart from fill-order replacement through the evicted block numbers. Random streams over 16 block numbers, with idle gaps and back-to-back accesses, fill sets and cycle through recency orders. These streams catch a wrong victim choice, a stale data word or a missed recency update. A reset in the middle of the random stream checks that old contents are really discarded.

// File: rtl/atd_pkg.sv
package atd_pkg;

   // Width of an index able to name n items (at least one bit).
   function automatic int unsigned bits_for(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Exact log2 of a power of two (0 for n == 1).
   function automatic int unsigned log2_exact(int unsigned n);
      return (n > 1) ? $clog2(n) : 0;
   endfunction

endpackage

// File: rtl/atd_tag_match.sv
module atd_tag_match #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned TAG_W = 7,
   parameter int unsigned WAY_W = 1
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic [TAG_W-1:0]            look_tag,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way
);

   logic [WAYS-1:0] eq;

   // one comparator per way, all in parallel
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = way_valid[w] && (way_tag[w] == look_tag);
   end

   assign hit = |eq;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (eq[w]) hit_way = hit_way | WAY_W'(w);
      end
   end

endmodule

// File: rtl/atd_victim_pick.sv
module atd_victim_pick #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned WAY_W = 1,
   parameter int unsigned AGE_W = 1
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
   output logic [WAY_W-1:0]            victim,
   output logic                        set_full
);

   if (WAYS == 1) begin : g_direct
      // no choice to make
      assign victim   = '0;
      assign set_full = way_valid[0];
   end else begin : g_assoc
      localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

      assign set_full = &way_valid;

      always_comb begin
         logic found;
         victim = '0;
         found  = 1'b0;
         // lowest-numbered empty way wins
         for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
               victim = WAY_W'(w);
               found  = 1'b1;
            end
         end
         // otherwise the way carrying the oldest age
         if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
               if (way_age[w] == OLDEST) victim = WAY_W'(w);
            end
         end
      end
   end

endmodule

// File: rtl/atd_age_update.sv
module atd_age_update #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned WAY_W = 1,
   parameter int unsigned AGE_W = 1
) (
   input  logic [WAYS-1:0][AGE_W-1:0]  old_age,
   input  logic [WAY_W-1:0]            touched,
   output logic [WAYS-1:0][AGE_W-1:0]  new_age
);

   if (WAYS == 1) begin : g_direct
      assign new_age = '0;
   end else begin : g_assoc
      logic [AGE_W-1:0] pivot;
      assign pivot = old_age[touched];

      for (genvar w = 0; w < WAYS; w++) begin : g_way
         always_comb begin
            if (WAY_W'(w) == touched)   new_age[w] = '0;
            else if (old_age[w] < pivot) new_age[w] = old_age[w] + AGE_W'(1);
            else                         new_age[w] = old_age[w];
         end
      end
   end

endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir
   import atd_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS = 4,
   parameter int unsigned WAYS       = 2,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_blk,
   input  logic [DATA_W-1:0]             req_fill_data,
   output logic                          rsp_valid,
   output logic                          rsp_hit,
   output logic [bits_for(WAYS)-1:0]     rsp_way,
   output logic                          rsp_evict_valid,
   output logic [ADDR_W-1:0]             rsp_evict_blk,
   output logic [DATA_W-1:0]             rsp_data
);

   localparam int unsigned SETS     = NUM_BLOCKS / WAYS;
   localparam int unsigned LOG_SETS = log2_exact(SETS);
   localparam int unsigned SET_W    = bits_for(SETS);
   localparam int unsigned WAY_W    = bits_for(WAYS);
   localparam int unsigned AGE_W    = WAY_W;
   localparam int unsigned TAG_W    = ADDR_W - LOG_SETS;

   // elaboration-time parameter checks
   if (WAYS == 0 || NUM_BLOCKS % WAYS != 0) begin : g_bad_ways
      $error("WAYS must divide NUM_BLOCKS");
   end
   if ((SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("set count must be a power of two");
   end
   if (ADDR_W <= LOG_SETS) begin : g_bad_addr
      $error("ADDR_W too small for the set index");
   end

   // storage
   logic [WAYS-1:0]                 valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]      tag_q   [SETS];
   logic [WAYS-1:0][DATA_W-1:0]     data_q  [SETS];
   logic [WAYS-1:0][AGE_W-1:0]      age_q   [SETS];

   // address split
   logic [SET_W-1:0]  set_idx;
   logic [TAG_W-1:0]  look_tag;

   assign look_tag = req_blk[ADDR_W-1:LOG_SETS];

   if (SETS == 1) begin : g_one_set
      assign set_idx = '0;
   end else begin : g_many_sets
      assign set_idx = req_blk[LOG_SETS-1:0];
   end

   // lookup of the selected set
   logic                        hit;
   logic [WAY_W-1:0]            hit_way;
   logic [WAY_W-1:0]            vic_way;
   logic                        set_full;
   logic [WAY_W-1:0]            touched;
   logic [WAYS-1:0][AGE_W-1:0]  next_age;
   logic [TAG_W-1:0]            vic_tag;
   logic [ADDR_W-1:0]           vic_blk;
   logic [DATA_W-1:0]           out_data;

   atd_tag_match #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .WAY_W (WAY_W)
   ) u_match (
      .way_valid (valid_q[set_idx]),
      .way_tag   (tag_q[set_idx]),
      .look_tag  (look_tag),
      .hit       (hit),
      .hit_way   (hit_way)
   );

   atd_victim_pick #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W),
      .AGE_W (AGE_W)
   ) u_victim (
      .way_valid (valid_q[set_idx]),
      .way_age   (age_q[set_idx]),
      .victim    (vic_way),
      .set_full  (set_full)
   );

   assign touched = hit ? hit_way : vic_way;

   atd_age_update #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W),
      .AGE_W (AGE_W)
   ) u_age (
      .old_age (age_q[set_idx]),
      .touched (touched),
      .new_age (next_age)
   );

   assign vic_tag = tag_q[set_idx][vic_way];

   if (SETS == 1) begin : g_evb_one
      assign vic_blk = vic_tag;
   end else begin : g_evb_many
      assign vic_blk = {vic_tag, set_idx};
   end

   assign out_data = hit ? data_q[set_idx][hit_way] : req_fill_data;

   // valid bits, recency and response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid       <= 1'b0;
         rsp_hit         <= 1'b0;
         rsp_way         <= '0;
         rsp_evict_valid <= 1'b0;
         rsp_evict_blk   <= '0;
         rsp_data        <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               age_q[s][w] <= AGE_W'(w);
            end
         end
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit         <= hit;
            rsp_way         <= touched;
            rsp_evict_valid <= !hit && set_full;
            rsp_evict_blk   <= vic_blk;
            rsp_data        <= out_data;
            age_q[set_idx]  <= next_age;
            if (!hit) valid_q[set_idx][vic_way] <= 1'b1;
         end
      end
   end

   // tag and data arrays need no reset
   always_ff @(posedge clk) begin
      if (rst_n && req_valid && !hit) begin
         tag_q[set_idx][vic_way]  <= look_tag;
         data_q[set_idx][vic_way] <= req_fill_data;
      end
   end

endmodule

// File: rtl/assoc_tag_dir_chk.sv
module assoc_tag_dir_chk #(
   parameter int unsigned WAYS   = 2,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WAY_W  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [ADDR_W-1:0]  req_blk,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic [WAY_W-1:0]   rsp_way,
   input logic               rsp_evict_valid
);

   logic              prev_valid;
   logic [ADDR_W-1:0] prev_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_valid <= 1'b0;
         prev_blk   <= '0;
      end else begin
         prev_valid <= req_valid;
         prev_blk   <= req_blk;
      end
   end

   a_r6_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r4_evict_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_evict_valid) |-> !rsp_hit);

   a_r2_repeat_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prev_valid && req_blk == prev_blk) |=> rsp_hit);

   a_r5_repeat_same_way: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prev_valid && req_blk == prev_blk) |=> (rsp_way == $past(rsp_way)));

   a_r8_direct_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (WAYS != 1 || rsp_way == '0));

   a_r3_way_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (32'(rsp_way) < WAYS));

endmodule

bind assoc_tag_dir assoc_tag_dir_chk #(
   .WAYS   (WAYS),
   .ADDR_W (ADDR_W),
   .WAY_W  (WAY_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_blk         (req_blk),
   .rsp_valid       (rsp_valid),
   .rsp_hit         (rsp_hit),
   .rsp_way         (rsp_way),
   .rsp_evict_valid (rsp_evict_valid)
);

// File: tb/test_assoc_tag_dir.sv
module test_assoc_tag_dir;

   localparam int NB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_blk = '0;
   logic [15:0] req_fill_data = '0;

   always #10 clk = ~clk; // 50 MHz

   // config 0: direct-mapped, 1: 2-way, 2: fully associative
   logic        dm_v, dm_h, dm_e;  logic [0:0] dm_w;  logic [7:0] dm_eb;  logic [15:0] dm_d;
   logic        tw_v, tw_h, tw_e;  logic [0:0] tw_w;  logic [7:0] tw_eb;  logic [15:0] tw_d;
   logic        fa_v, fa_h, fa_e;  logic [1:0] fa_w;  logic [7:0] fa_eb;  logic [15:0] fa_d;

   assoc_tag_dir #(.NUM_BLOCKS(NB), .WAYS(1)) i_dm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .req_fill_data(req_fill_data), .rsp_valid(dm_v), .rsp_hit(dm_h), .rsp_way(dm_w),
      .rsp_evict_valid(dm_e), .rsp_evict_blk(dm_eb), .rsp_data(dm_d));

   assoc_tag_dir i_assoc_tag_dir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .req_fill_data(req_fill_data), .rsp_valid(tw_v), .rsp_hit(tw_h), .rsp_way(tw_w),
      .rsp_evict_valid(tw_e), .rsp_evict_blk(tw_eb), .rsp_data(tw_d));

   assoc_tag_dir #(.NUM_BLOCKS(NB), .WAYS(4)) i_fa (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
      .req_fill_data(req_fill_data), .rsp_valid(fa_v), .rsp_hit(fa_h), .rsp_way(fa_w),
      .rsp_evict_valid(fa_e), .rsp_evict_blk(fa_eb), .rsp_data(fa_d));

   int o_v[3], o_h[3], o_w[3], o_e[3], o_eb[3], o_d[3];
   assign o_v[0] = int'(dm_v);  assign o_h[0] = int'(dm_h);  assign o_w[0] = int'(dm_w);
   assign o_e[0] = int'(dm_e);  assign o_eb[0] = int'(dm_eb); assign o_d[0] = int'(dm_d);
   assign o_v[1] = int'(tw_v);  assign o_h[1] = int'(tw_h);  assign o_w[1] = int'(tw_w);
   assign o_e[1] = int'(tw_e);  assign o_eb[1] = int'(tw_eb); assign o_d[1] = int'(tw_d);
   assign o_v[2] = int'(fa_v);  assign o_h[2] = int'(fa_h);  assign o_w[2] = int'(fa_w);
   assign o_e[2] = int'(fa_e);  assign o_eb[2] = int'(fa_eb); assign o_d[2] = int'(fa_d);

   int checks = 0;
   int failures = 0;

   // reference model, full block numbers stored per way
   int cfg_ways[3] = '{1, 2, 4};
   bit m_valid[3][4][4];
   int m_blk[3][4][4];
   int m_data[3][4][4];
   int m_age[3][4][4];

   // expected response of the pending access
   bit pend = 1'b0;
   int x_h[3], x_w[3], x_e[3], x_eb[3], x_d[3];

   // log of responses for directed checks
   int log_n = 0;
   int log_h[3][8], log_w[3][8], log_eb[3][8];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 3; c++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
               m_valid[c][s][w] = 1'b0;
               m_blk[c][s][w]   = 0;
               m_data[c][s][w]  = 0;
               m_age[c][s][w]   = w;
            end
   endtask

   task automatic model_access(int c, int blk, int dat);
      int ways = cfg_ways[c];
      int sets = NB / ways;
      int s = blk % sets;
      int t = -1;
      int pivot;
      for (int w = 0; w < ways; w++)
         if (m_valid[c][s][w] && m_blk[c][s][w] == blk) t = w;
      x_e[c]  = 0;
      x_eb[c] = -1;
      if (t >= 0) begin
         x_h[c] = 1;
         x_d[c] = m_data[c][s][t];
      end else begin
         x_h[c] = 0;
         x_d[c] = dat;
         for (int w = ways - 1; w >= 0; w--)
            if (!m_valid[c][s][w]) t = w;
         if (t < 0) begin
            for (int w = 0; w < ways; w++)
               if (m_age[c][s][w] == ways - 1) t = w;
            x_e[c]  = 1;
            x_eb[c] = m_blk[c][s][t];
         end
         m_valid[c][s][t] = 1'b1;
         m_blk[c][s][t]   = blk;
         m_data[c][s][t]  = dat;
      end
      x_w[c] = t;
      pivot = m_age[c][s][t];
      for (int w = 0; w < ways; w++)
         if (w != t && m_age[c][s][w] < pivot) m_age[c][s][w]++;
      m_age[c][s][t] = 0;
   endtask

   // one cycle: check the previous response, then drive a new request
   task automatic step(bit v, int blk, int dat);
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
         if (pend) begin
            chk(o_v[c] == 1, "R6", "rsp_valid after request", o_v[c], 1);
            chk(o_h[c] == x_h[c], "R2", "rsp_hit", o_h[c], x_h[c]);
            chk(o_w[c] == x_w[c], "R3", "rsp_way", o_w[c], x_w[c]);
            chk(o_e[c] == x_e[c], "R4", "rsp_evict_valid", o_e[c], x_e[c]);
            if (x_e[c] != 0)
               chk(o_eb[c] == x_eb[c], "R4", "rsp_evict_blk", o_eb[c], x_eb[c]);
            chk(o_d[c] == x_d[c], "R2", "rsp_data", o_d[c], x_d[c]);
            if (log_n < 8) begin
               log_h[c][log_n]  = o_h[c];
               log_w[c][log_n]  = o_w[c];
               log_eb[c][log_n] = o_e[c] != 0 ? o_eb[c] : -1;
            end
         end else begin
            chk(o_v[c] == 0, "R6", "rsp_valid while idle", o_v[c], 0);
         end
      end
      if (pend) log_n++;
      if (v) for (int c = 0; c < 3; c++) model_access(c, blk, dat);
      pend          = v;
      req_valid     = v;
      req_blk       = 8'(blk);
      req_fill_data = 16'(dat);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      req_valid = 1'b0;
      pend      = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      log_n = 0;
   endtask

   initial begin
      void'($urandom(32'd2718));
      do_reset();
      // R7: nothing reported straight after reset
      for (int c = 0; c < 3; c++)
         chk(o_v[c] == 0, "R7", "rsp_valid after reset", o_v[c], 0);

      // directed conflict sequence
      step(1, 0, 16'h1000);
      step(1, 8, 16'h1008);
      step(1, 0, 16'h2000);
      step(1, 6, 16'h1006);
      step(1, 8, 16'h2008);
      step(0, 0, 0);
      step(0, 0, 0);
      begin
         int pat_dm[5] = '{0, 0, 0, 0, 0};
         int pat_tw[5] = '{0, 0, 1, 0, 0};
         int pat_fa[5] = '{0, 0, 1, 0, 1};
         for (int k = 0; k < 5; k++) begin
            chk(log_h[0][k] == pat_dm[k], "R8", "direct-mapped hit pattern", log_h[0][k], pat_dm[k]);
            chk(log_w[0][k] == 0, "R8", "direct-mapped way", log_w[0][k], 0);
            chk(log_h[1][k] == pat_tw[k], "R9", "2-way hit pattern", log_h[1][k], pat_tw[k]);
            chk(log_h[2][k] == pat_fa[k], "R9", "4-way hit pattern", log_h[2][k], pat_fa[k]);
         end
         for (int c = 0; c < 3; c++)
            chk(log_w[c][0] == 0, "R7", "first fill way", log_w[c][0], 0);
         chk(log_w[1][1] == 1, "R3", "second block fills empty way 1", log_w[1][1], 1);
         chk(log_w[2][3] == 2, "R3", "4-way fills empty way 2", log_w[2][3], 2);
         chk(log_eb[2][3] == -1, "R3", "4-way no eviction on empty fill", log_eb[2][3], -1);
         chk(log_eb[1][3] == 8, "R9", "2-way fourth access evicts 8", log_eb[1][3], 8);
         chk(log_w[1][3] == 1, "R5", "hit on 0 made way 0 recent", log_w[1][3], 1);
         chk(log_eb[1][4] == 0, "R9", "2-way fifth access evicts 0", log_eb[1][4], 0);
         chk(log_eb[0][1] == 0, "R1", "block 8 conflicts with 0 in set 0", log_eb[0][1], 0);
      end

      // R1: blocks 1 and 5 share set 1 in the 2-way copy, 2 is apart
      do_reset();
      step(1, 1, 16'hAAAA);
      step(1, 5, 16'hBBBB);
      step(1, 2, 16'hCCCC);
      step(1, 9, 16'hDDDD);
      step(0, 0, 0);
      chk(log_w[1][1] == 1, "R1", "block 5 in same set as 1", log_w[1][1], 1);
      chk(log_w[1][2] == 0, "R1", "block 2 in its own set", log_w[1][2], 0);
      chk(log_eb[1][3] == 1, "R4", "block 9 evicts LRU block 1", log_eb[1][3], 1);

      // random mix with back-to-back traffic and a reset in the middle
      for (int i = 0; i < 4000; i++) begin
         if (i == 2000) begin
            step(0, 0, 0);
            do_reset();
         end
         step(($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 65536));
      end
      step(0, 0, 0);
      step(0, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule